// File: doc/BRIEF.md
# Enhanced PMP Permission Resolver

This block turns a set of physical memory protection entries into one access decision. Each entry supplies an 8-bit configuration byte and two precomputed flags. One flag says the first byte of the access lies inside the entry's region, the other says the last byte does. Address decoding is done upstream. The resolver takes those inputs together with the current privilege level, the requested read/write/execute set and two security policy bits. From them it produces the permission mask that applies to the access and a grant flag.

With the lockdown policy bit clear, the classic rule holds: machine mode is limited only by locked entries, and lower modes are always limited by the entry bits. With lockdown set, the lock bit changes meaning. It then marks a region as machine-only or shared, and two fixed 16-way decodes give the permission set for machine and for lower modes. A separate fallback policy covers accesses that hit no entry. That policy is tightened further by an allow-list-only bit. The result can be presented combinationally or through one register stage, chosen by a parameter.

Top module: `epmp_resolver`

## Requirements
- R1: Configuration byte layout: bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the region mode (value 0 means disabled, values 1 to 3 all enable the entry) and bit 7 is the lock. Requested sets and output masks use bit 0 for read, bit 1 for write and bit 2 for execute.
- R2: An entry takes part only when both of its range flags are 1 and its region mode is not 0.
- R3: When several entries take part, only the one with the lowest index decides the result.
- R4: With lockdown clear, a machine-mode access through an unlocked entry gets mask RWX (3'b111). A locked entry, or any access from a lower mode, gets exactly the entry's bits 2:0.
- R5: With lockdown set and machine mode, the index {lock, read, write, execute} (lock is the MSB) maps as follows: 0, 1, 4, 5, 6, 7 and 8 give nothing; 2, 3 and 14 give RW; 9 and 10 give X; 11 and 13 give RX; 12 and 15 give R. RWX is never given.
- R6: With lockdown set and a lower mode, the same index maps as follows: 0, 8, 9, 12, 13 and 14 give nothing; 1, 10 and 11 give X; 2, 4 and 15 give R; 3 and 6 give RW; 5 gives RX; 7 gives RWX.
- R7: When no entry takes part and the allow-list-only bit is set, the result is mask 0 and no grant in every mode, even for an empty request.
- R8: When an entry decides, the grant is 1 exactly when every requested bit is also set in the mask.
- R9: When no entry takes part, allow-list-only is clear and lockdown is set, a machine-mode request without execute is granted with mask RW (3'b011). Any other request gets mask 0 and no grant.
- R10: When no entry takes part and both policy bits are clear, machine mode gets mask RWX with grant. A lower mode gets mask 0 and no grant.
- R11: Privilege value 2'b11 is machine mode. Values 2'b00, 2'b01 and 2'b10 are all treated as lower modes.
- R12: With REG_OUT=1, the outputs follow the inputs one clock later. While reset is asserted, the outputs are mask 0 and grant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_cfg | input | NUM_ENTRIES*8 | Configuration bytes, entry i at bits 8i+7:8i |
| start_hit | input | NUM_ENTRIES | First byte of access inside entry i |
| end_hit | input | NUM_ENTRIES | Last byte of access inside entry i |
| priv_lvl | input | 2 | Current privilege level |
| acc_req | input | 3 | Requested permissions (R, W, X) |
| lockdown | input | 1 | Machine lockdown policy bit |
| allowlist_only | input | 1 | Deny-on-no-match policy bit |
| perm_mask | output | 3 | Permissions that apply to the access |
| access_ok | output | 1 | Access granted |

## Verification
Several decisions can arrive in the same cycle. A full match and a partial match land together when one entry has only its start flag set and a later entry has both flags set. Two full matches land together when two entries share the same region. An entry match also lands together with the set allow-list-only bit. The bench drives each of these pairings. It judges them against its own model, which must show the lowest fully matching entry winning and the fallback policy taking no part whenever any entry applies. Randomized cycles then mix all policy bits, privilege levels and match patterns, so that the entry path and the fallback path are compared cycle after cycle.

// File: rtl/epmp_pkg.sv
// Shared encodings and the lockdown permission decodes.
// Assumes the masks use bit 0 = R, bit 1 = W, bit 2 = X.
package epmp_pkg;
    localparam int CFG_W   = 8;
    localparam int R_BIT   = 0;
    localparam int W_BIT   = 1;
    localparam int X_BIT   = 2;
    localparam int MODE_LO = 3;
    localparam int L_BIT   = 7;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef logic [2:0] perm_t;
    localparam perm_t P_NONE = 3'b000;
    localparam perm_t P_R    = 3'b001;
    localparam perm_t P_RW   = 3'b011;
    localparam perm_t P_X    = 3'b100;
    localparam perm_t P_RX   = 3'b101;
    localparam perm_t P_RWX  = 3'b111;

    // Lockdown decode for machine-mode accesses, index {L,R,W,X}.
    function automatic perm_t lock_machine(input logic [3:0] idx);
        case (idx)
            4'd2, 4'd3, 4'd14:  lock_machine = P_RW;
            4'd9, 4'd10:        lock_machine = P_X;
            4'd11, 4'd13:       lock_machine = P_RX;
            4'd12, 4'd15:       lock_machine = P_R;
            default:            lock_machine = P_NONE;
        endcase
    endfunction

    // Lockdown decode for lower-mode accesses, index {L,R,W,X}.
    function automatic perm_t lock_lower(input logic [3:0] idx);
        case (idx)
            4'd1, 4'd10, 4'd11: lock_lower = P_X;
            4'd2, 4'd4, 4'd15:  lock_lower = P_R;
            4'd3, 4'd6:         lock_lower = P_RW;
            4'd5:               lock_lower = P_RX;
            4'd7:               lock_lower = P_RWX;
            default:            lock_lower = P_NONE;
        endcase
    endfunction
endpackage

// File: rtl/epmp_entry_sel.sv
// Finds the lowest-numbered applicable entry and forwards its config byte.
// Assumes the range flags are already qualified by upstream address decode.
module epmp_entry_sel
    import epmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic [NUM_ENTRIES*CFG_W-1:0] entry_cfg,
    input  logic [NUM_ENTRIES-1:0]       start_hit,
    input  logic [NUM_ENTRIES-1:0]       end_hit,
    output logic [NUM_ENTRIES-1:0]       sel_vec,
    output logic                         any_hit,
    output logic [CFG_W-1:0]             sel_cfg
);
    logic [NUM_ENTRIES-1:0] applies;

    // Per entry: both range flags set and region mode enabled.
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_apply
        assign applies[gi] = start_hit[gi] && end_hit[gi] &&
                             (entry_cfg[gi*CFG_W+MODE_LO +: 2] != 2'b00);
    end

    // Priority pick: the first applying entry from index 0 upward wins.
    always_comb begin
        logic found;
        found   = 1'b0;
        sel_vec = '0;
        sel_cfg = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (applies[i] && !found) begin
                found      = 1'b1;
                sel_vec[i] = 1'b1;
                sel_cfg    = entry_cfg[i*CFG_W +: CFG_W];
            end
        end
        any_hit = found;
    end
endmodule

// File: rtl/epmp_rule_eval.sv
// Computes the permission mask given by the deciding entry.
// Assumes cfg is the selected entry's byte; valid only when an entry hit.
module epmp_rule_eval
    import epmp_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             is_machine,
    input  logic             lockdown,
    output perm_t            mask
);
    logic [3:0] idx;
    logic       locked;

    assign locked = cfg[L_BIT];
    assign idx    = {cfg[L_BIT], cfg[R_BIT], cfg[W_BIT], cfg[X_BIT]};

    // Classic lock-and-mask rule, or one of the two lockdown decodes.
    always_comb begin
        if (!lockdown) begin
            mask = (is_machine && !locked) ? P_RWX : cfg[2:0];
        end else if (is_machine) begin
            mask = lock_machine(idx);
        end else begin
            mask = lock_lower(idx);
        end
    end
endmodule

// File: rtl/epmp_default_policy.sv
// Decides accesses that hit no entry from the two policy bits.
// Assumes the caller uses these outputs only when no entry applies.
module epmp_default_policy
    import epmp_pkg::*;
(
    input  logic  is_machine,
    input  perm_t req,
    input  logic  lockdown,
    input  logic  allowlist_only,
    output perm_t mask,
    output logic  grant
);
    // Fallback ordering: allow-list first, then lockdown, then classic.
    always_comb begin
        if (allowlist_only) begin
            mask  = P_NONE;
            grant = 1'b0;
        end else if (lockdown) begin
            grant = is_machine && !req[X_BIT];
            mask  = grant ? P_RW : P_NONE;
        end else begin
            grant = is_machine;
            mask  = is_machine ? P_RWX : P_NONE;
        end
    end
endmodule

// File: rtl/epmp_resolver.sv
// Top: combines entry selection, rule evaluation and the fallback policy,
// then presents the result directly or through one register (REG_OUT).
// Assumes priv_lvl 2'b11 is machine mode; synchronous active-low reset.
module epmp_resolver
    import epmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter bit REG_OUT     = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_ENTRIES*CFG_W-1:0] entry_cfg,
    input  logic [NUM_ENTRIES-1:0]       start_hit,
    input  logic [NUM_ENTRIES-1:0]       end_hit,
    input  logic [1:0]                   priv_lvl,
    input  logic [2:0]                   acc_req,
    input  logic                         lockdown,
    input  logic                         allowlist_only,
    output logic [2:0]                   perm_mask,
    output logic                         access_ok
);
    logic [NUM_ENTRIES-1:0] sel_vec;
    logic                   any_hit;
    logic [CFG_W-1:0]       sel_cfg;
    logic                   is_machine;
    perm_t                  rule_mask, def_mask, comb_mask;
    logic                   def_grant, comb_grant;

    assign is_machine = (priv_lvl == PRIV_MACHINE);

    epmp_entry_sel #(.NUM_ENTRIES(NUM_ENTRIES)) u_sel (
        .entry_cfg (entry_cfg),
        .start_hit (start_hit),
        .end_hit   (end_hit),
        .sel_vec   (sel_vec),
        .any_hit   (any_hit),
        .sel_cfg   (sel_cfg)
    );

    epmp_rule_eval u_rule (
        .cfg        (sel_cfg),
        .is_machine (is_machine),
        .lockdown   (lockdown),
        .mask       (rule_mask)
    );

    epmp_default_policy u_def (
        .is_machine     (is_machine),
        .req            (acc_req),
        .lockdown       (lockdown),
        .allowlist_only (allowlist_only),
        .mask           (def_mask),
        .grant          (def_grant)
    );

    // Choose the entry result or the fallback; grant needs a full subset.
    always_comb begin
        if (any_hit) begin
            comb_mask  = rule_mask;
            comb_grant = ((acc_req & ~rule_mask) == 3'b000);
        end else begin
            comb_mask  = def_mask;
            comb_grant = def_grant;
        end
    end

    if (REG_OUT) begin : g_reg
        logic [2:0] mask_q;
        logic       ok_q;
        // Output stage: one cycle of latency, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                ok_q   <= 1'b0;
            end else begin
                mask_q <= comb_mask;
                ok_q   <= comb_grant;
            end
        end
        assign perm_mask = mask_q;
        assign access_ok = ok_q;

        // R12: registered outputs track the previous cycle's decision.
        p_reg_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (perm_mask == $past(comb_mask) && access_ok == $past(comb_grant)));
    end else begin : g_comb
        assign perm_mask = comb_mask;
        assign access_ok = comb_grant;
    end

    // R3: at most one entry is ever chosen.
    p_single_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec));

    // R7: allow-list-only with no hit denies everything.
    p_allowlist_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_hit && allowlist_only) |-> (comb_mask == P_NONE && !comb_grant));

    // R8: a grant never exceeds the mask.
    p_grant_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comb_grant |-> ((acc_req & ~comb_mask) == 3'b000));

    // R5: machine mode under lockdown never obtains RWX through an entry.
    p_no_rwx_machine_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && lockdown && is_machine) |-> (comb_mask != P_RWX));
endmodule

// File: tb/epmp_resolver_tb.sv
// Scoreboard bench: a driver computes expected results into a queue, a
// monitor pops them as the registered outputs appear.
module epmp_resolver_tb;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*8-1:0] entry_cfg = '0;
    logic [N-1:0]   start_hit = '0;
    logic [N-1:0]   end_hit = '0;
    logic [1:0]     priv_lvl = 2'b00;
    logic [2:0]     acc_req = 3'b000;
    logic           lockdown = 1'b0;
    logic           allowlist_only = 1'b0;
    logic [2:0]     perm_mask;
    logic           access_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] m;
        logic       g;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    epmp_resolver #(.NUM_ENTRIES(N), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .entry_cfg(entry_cfg),
        .start_hit(start_hit), .end_hit(end_hit), .priv_lvl(priv_lvl),
        .acc_req(acc_req), .lockdown(lockdown),
        .allowlist_only(allowlist_only),
        .perm_mask(perm_mask), .access_ok(access_ok)
    );

    function automatic logic [7:0] mk(input bit l, input logic [1:0] md,
                                      input bit x, input bit w, input bit r);
        return {l, 2'b00, md, x, w, r};
    endfunction

    // Independent model: lockdown tables held as per-permission index sets.
    function automatic item_t model(input logic [N*8-1:0] c, input logic [N-1:0] s,
                                    input logic [N-1:0] e, input logic [1:0] pl,
                                    input logic [2:0] rq, input bit mml, input bit mmwp);
        item_t it;
        bit mach = (pl == 2'b11);
        bit hit = 1'b0;
        logic [7:0] b = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (s[i] && e[i] && c[i*8+3 +: 2] != 2'b00) begin
                hit = 1'b1;
                b = c[i*8 +: 8];
            end
        end
        if (hit) begin
            if (!mml) begin
                it.m = (mach && !b[7]) ? 3'b111 : b[2:0];
            end else begin
                int ix = {b[7], b[0], b[1], b[2]};
                logic [15:0] tr = mach ? 16'hF80C : 16'h80FC;
                logic [15:0] tw = mach ? 16'h400C : 16'h00C8;
                logic [15:0] tx = mach ? 16'h2E00 : 16'h0CA2;
                it.m = {tx[ix], tw[ix], tr[ix]};
            end
            it.g = ((rq & ~it.m) == 3'b000);
        end else if (mmwp) begin
            it.m = 3'b000; it.g = 1'b0;
        end else if (mml) begin
            it.g = mach && !rq[2];
            it.m = it.g ? 3'b011 : 3'b000;
        end else begin
            it.g = mach;
            it.m = mach ? 3'b111 : 3'b000;
        end
        return it;
    endfunction

    task automatic send(input logic [N*8-1:0] c, input logic [N-1:0] s,
                        input logic [N-1:0] e, input logic [1:0] pl,
                        input logic [2:0] rq, input bit mml, input bit mmwp,
                        input string tag);
        item_t it;
        @(negedge clk);
        entry_cfg = c; start_hit = s; end_hit = e; priv_lvl = pl;
        acc_req = rq; lockdown = mml; allowlist_only = mmwp;
        it = model(c, s, e, pl, rq, mml, mmwp);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: after each edge, the head item belongs to the previous drive.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (perm_mask !== it.m || access_ok !== it.g) begin
                errors++;
                $display("FAIL %s: mask=%b ok=%b expected mask=%b ok=%b",
                         it.tag, perm_mask, access_ok, it.m, it.g);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: finished=0 expected finished=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [N*8-1:0] c;
        // R12: reset holds outputs at zero even with a granting input.
        priv_lvl = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (perm_mask !== 3'b000 || access_ok !== 1'b0) begin
            errors++;
            $display("FAIL R12: mask=%b ok=%b expected mask=000 ok=0", perm_mask, access_ok);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: every nonzero mode value enables an entry; bits map R/W/X.
        for (int md = 1; md < 4; md++) begin
            c = '0; c[7:0] = mk(1'b0, md[1:0], 1'b0, 1'b1, 1'b0);
            send(c, 8'h01, 8'h01, 2'b00, 3'b010, 1'b0, 1'b0, "R1");
        end
        c = '0; c[7:0] = mk(1'b0, 2'b01, 1'b1, 1'b0, 1'b1);
        send(c, 8'h01, 8'h01, 2'b00, 3'b101, 1'b0, 1'b0, "R1");
        // R2: partial match and disabled mode do not apply.
        c = '0; c[7:0] = mk(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        c[15:8] = mk(1'b1, 2'b11, 1'b0, 1'b0, 1'b1);
        send(c, 8'h03, 8'h02, 2'b00, 3'b001, 1'b0, 1'b0, "R2");
        c[7:0] = mk(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        send(c, 8'h03, 8'h03, 2'b11, 3'b111, 1'b0, 1'b0, "R2");
        send(c, 8'h01, 8'h01, 2'b11, 3'b111, 1'b0, 1'b1, "R2");
        // R3: two full matches, lowest index wins.
        c = '0; c[23:16] = mk(1'b0, 2'b10, 1'b1, 1'b0, 1'b0);
        c[47:40] = mk(1'b0, 2'b10, 1'b0, 1'b1, 1'b1);
        send(c, 8'h24, 8'h24, 2'b00, 3'b001, 1'b0, 1'b0, "R3");
        send(c, 8'h24, 8'h24, 2'b00, 3'b100, 1'b0, 1'b0, "R3");
        send(c, 8'h24, 8'h20, 2'b00, 3'b011, 1'b0, 1'b0, "R3");
        // R4: classic rule.
        c = '0; c[7:0] = mk(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        send(c, 8'h01, 8'h01, 2'b11, 3'b111, 1'b0, 1'b0, "R4");
        c[7:0] = mk(1'b1, 2'b01, 1'b0, 1'b0, 1'b1);
        send(c, 8'h01, 8'h01, 2'b11, 3'b010, 1'b0, 1'b0, "R4");
        c[7:0] = mk(1'b0, 2'b01, 1'b0, 1'b1, 1'b0);
        send(c, 8'h01, 8'h01, 2'b01, 3'b010, 1'b0, 1'b0, "R4");
        // R5 / R6: sweep every table index in both modes.
        for (int ix = 0; ix < 16; ix++) begin
            c = '0;
            c[7:0] = mk(ix[3], 2'b01, ix[0], ix[1], ix[2]);
            send(c, 8'h01, 8'h01, 2'b11, 3'b000, 1'b1, 1'b0, "R5");
            send(c, 8'h01, 8'h01, 2'b00, 3'b000, 1'b1, 1'b0, "R6");
        end
        // R8: request beyond the mask is refused.
        c = '0; c[7:0] = mk(1'b1, 2'b01, 1'b0, 1'b0, 1'b1);
        send(c, 8'h01, 8'h01, 2'b00, 3'b011, 1'b0, 1'b0, "R8");
        send(c, 8'h01, 8'h01, 2'b00, 3'b000, 1'b0, 1'b0, "R8");
        // R7: allow-list-only with no hit, also with empty request.
        send('0, '0, '0, 2'b11, 3'b000, 1'b0, 1'b1, "R7");
        send('0, '0, '0, 2'b11, 3'b001, 1'b1, 1'b1, "R7");
        // R9: lockdown fallback.
        send('0, '0, '0, 2'b11, 3'b011, 1'b1, 1'b0, "R9");
        send('0, '0, '0, 2'b11, 3'b101, 1'b1, 1'b0, "R9");
        send('0, '0, '0, 2'b01, 3'b001, 1'b1, 1'b0, "R9");
        // R10: classic fallback.
        send('0, '0, '0, 2'b11, 3'b111, 1'b0, 1'b0, "R10");
        send('0, '0, '0, 2'b01, 3'b000, 1'b0, 1'b0, "R10");
        // R11: level 2'b10 is a lower mode.
        send('0, '0, '0, 2'b10, 3'b001, 1'b0, 1'b0, "R11");
        c = '0; c[7:0] = mk(1'b0, 2'b01, 1'b0, 1'b0, 1'b1);
        send(c, 8'h01, 8'h01, 2'b10, 3'b010, 1'b0, 1'b0, "R11");
        // Random mix of all paths (R3 R5 R6 R8 R9 R10).
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < N; i++) c[i*8 +: 8] = 8'($urandom);
            send(c, N'($urandom), N'($urandom), 2'($urandom), 3'($urandom),
                 1'($urandom), 1'($urandom), "R3_R5_R6_R8_rand");
        end
        // R12: output changes only after the next edge.
        send('0, '0, '0, 2'b11, 3'b000, 1'b0, 1'b0, "R12");
        send('0, '0, '0, 2'b00, 3'b000, 1'b0, 1'b0, "R12");
        repeat (4) @(posedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule